// File: doc/BRIEF.md
# PS/2 Mouse Command and Mode Processor

This block sits between the serial link layer of a PS/2 pointing device and the logic that builds movement reports. The link layer presents each byte it receives from the host on `rx_data`, together with a one-cycle `rx_valid` pulse and an `rx_err` flag for parity or framing faults. The block decodes each byte as a command or as the argument of a two-byte command. It updates the device configuration, which covers the sample rate, the resolution code, stream or remote mode, reporting enable, autospeed and wrap (echo) mode. It then places the reply bytes in a small response queue that the link layer drains.

The receive side has no back-pressure: every `rx_valid` pulse is taken in the cycle it occurs. The transmit side is valid/ready. `tx_valid` stays high and `tx_data` holds steady until the link layer raises `tx_ready`, and one byte leaves on each cycle in which both are high. A new host byte discards any reply bytes not yet sent and replaces them with the reply to that byte, which appears on the cycle after the byte arrives. The block also drives a level to the report builder that permits stream reports, a one-cycle strobe that clears the movement accumulators, and the live configuration fields. For a Read Data command, the block copies the current report from `rpt_data` into the reply.

Top module: `mouse_cmd_engine`

## Requirements
- R1: After reset the configuration is rate 0x64, resolution code 2, stream mode, reporting disabled, autospeed off and wrap off. The first bytes offered on the transmit side are 0xAA then 0x00.
- R2: Byte 0xFF is answered 0xFA, 0xAA, 0x00 and restores every R1 setting, including leaving wrap mode. It acts as a reset even while an argument byte is awaited.
- R3: Every accepted command except 0xFE is answered first with 0xFA. 0xF4 and 0xF5 set and clear enable. 0xF0 selects remote mode and 0xEA selects stream mode. 0xE7 and 0xE6 set and clear autospeed. 0xF6 restores the R1 settings. 0xEC outside wrap mode is answered 0xFA only.
- R4: 0xF3 and 0xE8 are answered 0xFA and then take one argument byte. For 0xF3 the legal rates are 0x0A, 0x14, 0x28, 0x3C, 0x50, 0x64 and 0xC8. For 0xE8 the legal codes are 0x00 to 0x03. A legal argument is applied and answered 0xFA.
- R5: A byte flagged by `rx_err`, an unknown command or an illegal argument is answered 0xFE and changes no setting. While an argument is awaited, such a byte leaves the block still waiting for it. A second such byte directly after the first is answered 0xFC, and the run count then restarts, so a third is answered 0xFE again.
- R6: 0xFE re-sends the last reply packet. A 0xFE reply for bad input is never kept as the last packet. After reset the last packet is 0xAA, 0x00.
- R7: 0xEE is answered 0xFA and enters wrap mode. In wrap mode every good byte is echoed unchanged with no other effect, except 0xEC and 0xFF. 0xEC is answered 0xFA and leaves wrap with stream/remote, enable, rate, resolution and autospeed as they were. 0xFF resets as in R2.
- R8: 0xF2 is answered 0xFA, 0x00. 0xEB is answered 0xFA followed by `rpt_data[7:0]`, `rpt_data[15:8]`, `rpt_data[23:16]`. 0xE9 is answered 0xFA, a status byte, the resolution code and the rate. The status byte has bit0 = right button, bit1 = middle, bit2 = left, bit4 = autospeed, bit5 = enable, bit6 = remote, and bits 3 and 7 zero.
- R9: `ctr_clr` is high for exactly the one cycle after each accepted command other than 0xFE, including 0xEC and 0xFF in wrap mode. It stays low for argument bytes, echoed bytes, bad bytes and 0xFE.
- R10: Under `tx_ready` low, `tx_valid` and `tx_data` hold steady. A new host byte drops unsent reply bytes, and its own reply starts on the next cycle.
- R11: `stream_on` is high exactly when the block is in stream mode, enabled and not in wrap mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle pulse: host byte on rx_data |
| rx_data | input | 8 | Received host byte |
| rx_err | input | 1 | Byte arrived with a parity or framing fault |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Link layer takes the reply byte this cycle |
| btn | input | 3 | Debounced buttons: bit0 left, bit1 right, bit2 middle |
| rpt_data | input | 24 | Current three-byte movement report, first byte in bits 7:0 |
| stream_on | output | 1 | Report builder may send stream reports |
| ctr_clr | output | 1 | Clear movement accumulators (one-cycle strobe) |
| cfg_rate | output | 8 | Sample rate in reports per second |
| cfg_res | output | 2 | Resolution code |
| cfg_remote | output | 1 | 1 = remote mode, 0 = stream mode |
| cfg_enable | output | 1 | Reporting enabled |
| cfg_autospeed | output | 1 | Autospeed on |
| cfg_wrap | output | 1 | Wrap (echo) mode on |

## Verification
The bench targets the resend rule. A design that stored its own 0xFE error reply as the last packet would answer a later 0xFE with 0xFE instead of the earlier reply. It also runs the bad-input escalation through three bad bytes in a row. A design that counted wrongly would send 0xFC too early, or never go back to 0xFE after the 0xFC. Illegal arguments after 0xF3 and 0xE8 must leave rate and resolution untouched, and 0xFF must still reset while an argument is pending. In wrap mode the bench sends command codes such as 0xF5 and 0xFE, which must come back as echoes without acting. It then leaves wrap from remote mode, where a design that forced stream mode on exit would show up. Finally the bench holds `tx_ready` low to check that the reply byte does not move, and sends a new command over an undrained reply to check that stale bytes are dropped.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int BYTE_W  = 8;
  localparam int PKT_MAX = 4;
  localparam int LEN_W   = $clog2(PKT_MAX + 1);

  // host command codes
  localparam logic [7:0] C_RESET    = 8'hFF;
  localparam logic [7:0] C_RESEND   = 8'hFE;
  localparam logic [7:0] C_DEFAULT  = 8'hF6;
  localparam logic [7:0] C_DISABLE  = 8'hF5;
  localparam logic [7:0] C_ENABLE   = 8'hF4;
  localparam logic [7:0] C_RATE     = 8'hF3;
  localparam logic [7:0] C_DEVID    = 8'hF2;
  localparam logic [7:0] C_REMOTE   = 8'hF0;
  localparam logic [7:0] C_WRAP     = 8'hEE;
  localparam logic [7:0] C_UNWRAP   = 8'hEC;
  localparam logic [7:0] C_READ     = 8'hEB;
  localparam logic [7:0] C_STREAM   = 8'hEA;
  localparam logic [7:0] C_STATUS   = 8'hE9;
  localparam logic [7:0] C_RES      = 8'hE8;
  localparam logic [7:0] C_AUTO_ON  = 8'hE7;
  localparam logic [7:0] C_AUTO_OFF = 8'hE6;

  // reply codes
  localparam logic [7:0] R_ACK   = 8'hFA;
  localparam logic [7:0] R_AGAIN = 8'hFE;
  localparam logic [7:0] R_FAULT = 8'hFC;
  localparam logic [7:0] R_PASS  = 8'hAA;
  localparam logic [7:0] R_ID    = 8'h00;

  typedef enum logic [1:0] {ARG_NONE, ARG_RATE, ARG_RES} arg_e;

  typedef struct packed {
    logic [7:0] rate;
    logic [1:0] res;
    logic       remote;
    logic       enable;
    logic       autospeed;
    logic       wrap;
  } cfg_t;

  localparam cfg_t DEF_CFG = '{rate: 8'h64, res: 2'd2, remote: 1'b0,
                               enable: 1'b0, autospeed: 1'b0, wrap: 1'b0};
endpackage

// File: rtl/mce_byte_check.sv
module mce_byte_check
  import mce_pkg::*;
(
  input  logic [7:0] byte_in,
  output logic       is_cmd,
  output logic       rate_ok,
  output logic       res_ok
);
  always_comb begin
    unique case (byte_in)
      C_RESET, C_RESEND, C_DEFAULT, C_DISABLE, C_ENABLE, C_RATE, C_DEVID,
      C_REMOTE, C_WRAP, C_UNWRAP, C_READ, C_STREAM, C_STATUS, C_RES,
      C_AUTO_ON, C_AUTO_OFF: is_cmd = 1'b1;
      default:               is_cmd = 1'b0;
    endcase
  end

  always_comb begin
    unique case (byte_in)
      8'h0A, 8'h14, 8'h28, 8'h3C, 8'h50, 8'h64, 8'hC8: rate_ok = 1'b1;
      default:                                         rate_ok = 1'b0;
    endcase
  end

  assign res_ok = (byte_in[7:2] == 6'd0);
endmodule

// File: rtl/mce_resp_queue.sv
module mce_resp_queue #(
  parameter  int DEPTH = 4,
  parameter  int WIDTH = 8,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [LW-1:0]          load_len,
  input  logic [DEPTH*WIDTH-1:0] load_data,
  output logic                   tx_valid,
  output logic [WIDTH-1:0]       tx_data,
  input  logic                   tx_ready
);
  logic [DEPTH-1:0][WIDTH-1:0] mem;
  logic [LW-1:0]               cnt;
  logic [LW-1:0]               rd;

  assign tx_valid = (rd < cnt);
  assign tx_data  = mem[rd[IW-1:0]];

  // a load replaces whatever is still waiting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
      cnt <= '0;
      rd  <= '0;
    end else if (load) begin
      mem <= load_data;
      cnt <= load_len;
      rd  <= '0;
    end else if (tx_valid && tx_ready) begin
      rd <= rd + 1'b1;
    end
  end

  assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/mouse_cmd_engine.sv
module mouse_cmd_engine
  import mce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_err,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic [2:0]  btn,
  input  logic [23:0] rpt_data,
  output logic        stream_on,
  output logic        ctr_clr,
  output logic [7:0]  cfg_rate,
  output logic [1:0]  cfg_res,
  output logic        cfg_remote,
  output logic        cfg_enable,
  output logic        cfg_autospeed,
  output logic        cfg_wrap
);
  cfg_t                           cfg, cfg_n;
  arg_e                           arg, arg_n;
  logic                           err_pend, err_pend_n;
  logic                           boot;
  logic                           clr_q, clr_n;
  logic [PKT_MAX-1:0][BYTE_W-1:0] last_pkt, pkt;
  logic [LEN_W-1:0]               last_len, pkt_len;
  logic                           ld, keep;
  logic                           is_cmd, rate_ok, res_ok, bad;
  logic [7:0]                     status_b;

  mce_byte_check u_check (
    .byte_in (rx_data),
    .is_cmd  (is_cmd),
    .rate_ok (rate_ok),
    .res_ok  (res_ok)
  );

  always_comb begin
    unique case (arg)
      ARG_RATE: bad = !rate_ok;
      ARG_RES:  bad = !res_ok;
      default:  bad = !is_cmd;
    endcase
  end

  assign status_b = {1'b0, cfg.remote, cfg.enable, cfg.autospeed, 1'b0,
                     btn[0], btn[2], btn[1]};

  always_comb begin
    cfg_n      = cfg;
    arg_n      = arg;
    err_pend_n = err_pend;
    clr_n      = 1'b0;
    ld         = 1'b0;
    keep       = 1'b0;
    pkt        = '0;
    pkt_len    = '0;
    if (rx_valid) begin
      ld = 1'b1;
      if (!rx_err && rx_data == C_RESET) begin
        pkt[0] = R_ACK; pkt[1] = R_PASS; pkt[2] = R_ID; pkt_len = 3;
        cfg_n = DEF_CFG; arg_n = ARG_NONE; err_pend_n = 1'b0;
        keep = 1'b1; clr_n = 1'b1;
      end else if (cfg.wrap && !rx_err && rx_data != C_UNWRAP) begin
        pkt[0] = rx_data; pkt_len = 1;
        keep = 1'b1; err_pend_n = 1'b0;
      end else if (rx_err || bad) begin
        pkt_len = 1;
        if (err_pend) begin
          pkt[0] = R_FAULT; keep = 1'b1; err_pend_n = 1'b0;
        end else begin
          pkt[0] = R_AGAIN; err_pend_n = 1'b1;
        end
      end else if (arg != ARG_NONE) begin
        if (arg == ARG_RATE) cfg_n.rate = rx_data;
        else                 cfg_n.res  = rx_data[1:0];
        arg_n = ARG_NONE; err_pend_n = 1'b0;
        pkt[0] = R_ACK; pkt_len = 1; keep = 1'b1;
      end else if (rx_data == C_RESEND) begin
        pkt = last_pkt; pkt_len = last_len; err_pend_n = 1'b0;
      end else begin
        err_pend_n = 1'b0;
        pkt[0] = R_ACK; pkt_len = 1; keep = 1'b1; clr_n = 1'b1;
        unique case (rx_data)
          C_DEFAULT:  cfg_n = DEF_CFG;
          C_DISABLE:  cfg_n.enable = 1'b0;
          C_ENABLE:   cfg_n.enable = 1'b1;
          C_RATE:     arg_n = ARG_RATE;
          C_DEVID:    begin pkt[1] = R_ID; pkt_len = 2; end
          C_REMOTE:   cfg_n.remote = 1'b1;
          C_WRAP:     cfg_n.wrap = 1'b1;
          C_UNWRAP:   cfg_n.wrap = 1'b0;
          C_READ:     begin
                        pkt[1] = rpt_data[7:0]; pkt[2] = rpt_data[15:8];
                        pkt[3] = rpt_data[23:16]; pkt_len = 4;
                      end
          C_STREAM:   cfg_n.remote = 1'b0;
          C_STATUS:   begin
                        pkt[1] = status_b; pkt[2] = {6'd0, cfg.res};
                        pkt[3] = cfg.rate; pkt_len = 4;
                      end
          C_RES:      arg_n = ARG_RES;
          C_AUTO_ON:  cfg_n.autospeed = 1'b1;
          C_AUTO_OFF: cfg_n.autospeed = 1'b0;
          default:    ;
        endcase
      end
    end else if (boot) begin
      ld = 1'b1; keep = 1'b1;
      pkt[0] = R_PASS; pkt[1] = R_ID; pkt_len = 2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= DEF_CFG;
      arg      <= ARG_NONE;
      err_pend <= 1'b0;
      boot     <= 1'b1;
      clr_q    <= 1'b0;
      last_pkt <= {8'h00, 8'h00, R_ID, R_PASS};
      last_len <= 2;
    end else begin
      cfg      <= cfg_n;
      arg      <= arg_n;
      err_pend <= err_pend_n;
      boot     <= 1'b0;
      clr_q    <= clr_n;
      if (ld && keep) begin
        last_pkt <= pkt;
        last_len <= pkt_len;
      end
    end
  end

  mce_resp_queue #(.DEPTH(PKT_MAX), .WIDTH(BYTE_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .load_len  (pkt_len),
    .load_data (pkt),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
  );

  assign stream_on     = !cfg.remote && cfg.enable && !cfg.wrap;
  assign ctr_clr       = clr_q;
  assign cfg_rate      = cfg.rate;
  assign cfg_res       = cfg.res;
  assign cfg_remote    = cfg.remote;
  assign cfg_enable    = cfg.enable;
  assign cfg_autospeed = cfg.autospeed;
  assign cfg_wrap      = cfg.wrap;

  assert_echo_in_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wrap && rx_valid && !rx_err && rx_data != C_UNWRAP && rx_data != C_RESET)
    |=> (tx_valid && tx_data == $past(rx_data)));

  assert_fault_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err) |=> (tx_valid && (tx_data == R_AGAIN || tx_data == R_FAULT)));

  assert_fault_keeps_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err) |=> (cfg_rate == $past(cfg_rate) && cfg_res == $past(cfg_res) &&
                              cfg_enable == $past(cfg_enable) && cfg_wrap == $past(cfg_wrap)));

  assert_clear_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clr |-> ($past(rx_valid) && !$past(rx_err)));

  assert_rate_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rate == 8'h0A || cfg_rate == 8'h14 || cfg_rate == 8'h28 || cfg_rate == 8'h3C ||
     cfg_rate == 8'h50 || cfg_rate == 8'h64 || cfg_rate == 8'hC8));
endmodule

// File: tb/test_mouse_cmd_engine.sv
module test_mouse_cmd_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_err = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;
  logic [2:0]  btn = 3'b000;
  logic [23:0] rpt_data = 24'h03F109;
  logic        stream_on, ctr_clr;
  logic [7:0]  cfg_rate;
  logic [1:0]  cfg_res;
  logic        cfg_remote, cfg_enable, cfg_autospeed, cfg_wrap;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mouse_cmd_engine i_mouse_cmd_engine (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .btn(btn),
    .rpt_data(rpt_data), .stream_on(stream_on), .ctr_clr(ctr_clr),
    .cfg_rate(cfg_rate), .cfg_res(cfg_res), .cfg_remote(cfg_remote),
    .cfg_enable(cfg_enable), .cfg_autospeed(cfg_autospeed), .cfg_wrap(cfg_wrap)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one host byte; returns at the negedge after the capturing edge
  task automatic send_byte(input logic [7:0] b, input logic e, output logic clr);
    rx_data = b; rx_err = e; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
    clr = ctr_clr;
  endtask

  task automatic expect_bytes(input int n, input logic [7:0] e [4], input string req);
    tx_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk(tx_valid === 1'b1, req, "tx_valid during reply", int'(tx_valid), 1);
      chk(tx_data === e[i], req, $sformatf("reply byte %0d", i), int'(tx_data), int'(e[i]));
      @(negedge clk);
    end
    chk(tx_valid === 1'b0, req, "reply length", int'(tx_valid), 0);
    tx_ready = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b, input int n, input logic [7:0] e [4], input string req);
    logic c;
    send_byte(b, 1'b0, c);
    expect_bytes(n, e, req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(cfg_rate == 8'h64, "R1", "rate", cfg_rate, 8'h64);
    chk(cfg_res == 2'd2, "R1", "res", cfg_res, 2);
    chk({cfg_remote, cfg_enable, cfg_autospeed, cfg_wrap} == 4'b0000, "R1", "mode flags",
        {cfg_remote, cfg_enable, cfg_autospeed, cfg_wrap}, 0);
    chk(stream_on == 1'b0, "R11", "stream_on after reset", stream_on, 0);
    @(negedge clk);
    expect_bytes(2, '{8'hAA, 8'h00, 8'h00, 8'h00}, "R1");
  endtask

  task automatic t_modes;
    logic c;
    send_byte(8'hF4, 1'b0, c);
    chk(c == 1'b1, "R9", "ctr_clr after F4", c, 1);
    expect_bytes(1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_enable == 1'b1 && stream_on == 1'b1, "R11", "enabled stream", stream_on, 1);
    cmd(8'hF0, 1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_remote == 1'b1 && stream_on == 1'b0, "R11", "remote blocks stream", stream_on, 0);
    cmd(8'hEA, 1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_remote == 1'b0, "R3", "EA stream", cfg_remote, 0);
    cmd(8'hE7, 1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_autospeed == 1'b1, "R3", "E7 autospeed", cfg_autospeed, 1);
    cmd(8'hE6, 1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_autospeed == 1'b0, "R3", "E6 autospeed", cfg_autospeed, 0);
    cmd(8'hF5, 1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_enable == 1'b0, "R3", "F5 disable", cfg_enable, 0);
    cmd(8'hEC, 1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_wrap == 1'b0, "R3", "EC outside wrap", cfg_wrap, 0);
    cmd(8'hE7, 1, '{8'hFA, 0, 0, 0}, "R3");
    cmd(8'hF6, 1, '{8'hFA, 0, 0, 0}, "R3");
    chk(cfg_autospeed == 1'b0 && cfg_rate == 8'h64, "R3", "F6 defaults", cfg_autospeed, 0);
  endtask

  task automatic t_params;
    logic c;
    cmd(8'hF4, 1, '{8'hFA, 0, 0, 0}, "R3");
    cmd(8'hF3, 1, '{8'hFA, 0, 0, 0}, "R4");
    send_byte(8'h33, 1'b0, c);
    expect_bytes(1, '{8'hFE, 0, 0, 0}, "R5");
    chk(cfg_rate == 8'h64, "R5", "rate after bad arg", cfg_rate, 8'h64);
    send_byte(8'h28, 1'b0, c);
    chk(c == 1'b0, "R9", "no clear on argument", c, 0);
    expect_bytes(1, '{8'hFA, 0, 0, 0}, "R4");
    chk(cfg_rate == 8'h28, "R4", "rate applied", cfg_rate, 8'h28);
    cmd(8'hE8, 1, '{8'hFA, 0, 0, 0}, "R4");
    cmd(8'h04, 1, '{8'hFE, 0, 0, 0}, "R5");
    chk(cfg_res == 2'd2, "R5", "res after bad arg", cfg_res, 2);
    cmd(8'h03, 1, '{8'hFA, 0, 0, 0}, "R4");
    chk(cfg_res == 2'd3, "R4", "res applied", cfg_res, 3);
    cmd(8'hF3, 1, '{8'hFA, 0, 0, 0}, "R4");
    send_byte(8'hFF, 1'b0, c);
    chk(c == 1'b1, "R9", "ctr_clr after FF", c, 1);
    expect_bytes(3, '{8'hFA, 8'hAA, 8'h00, 0}, "R2");
    chk(cfg_rate == 8'h64 && cfg_res == 2'd2 && cfg_enable == 1'b0, "R2", "FF defaults",
        cfg_rate, 8'h64);
  endtask

  task automatic t_resend;
    logic c;
    cmd(8'hF2, 2, '{8'hFA, 8'h00, 0, 0}, "R8");
    send_byte(8'h55, 1'b0, c);
    chk(c == 1'b0, "R9", "no clear on bad byte", c, 0);
    expect_bytes(1, '{8'hFE, 0, 0, 0}, "R5");
    send_byte(8'hFE, 1'b0, c);
    chk(c == 1'b0, "R9", "no clear on resend", c, 0);
    expect_bytes(2, '{8'hFA, 8'h00, 0, 0}, "R6");
    cmd(8'h55, 1, '{8'hFE, 0, 0, 0}, "R5");
    cmd(8'h55, 1, '{8'hFC, 0, 0, 0}, "R5");
    cmd(8'h55, 1, '{8'hFE, 0, 0, 0}, "R5");
    cmd(8'hFE, 1, '{8'hFC, 0, 0, 0}, "R6");
    send_byte(8'hF4, 1'b1, c);
    expect_bytes(1, '{8'hFE, 0, 0, 0}, "R5");
    chk(cfg_enable == 1'b0, "R5", "flagged byte ignored", cfg_enable, 0);
    cmd(8'hF2, 2, '{8'hFA, 8'h00, 0, 0}, "R8");
  endtask

  task automatic t_wrap;
    logic c;
    cmd(8'hF4, 1, '{8'hFA, 0, 0, 0}, "R3");
    cmd(8'hEE, 1, '{8'hFA, 0, 0, 0}, "R7");
    chk(cfg_wrap == 1'b1 && stream_on == 1'b0, "R11", "wrap blocks stream", stream_on, 0);
    send_byte(8'h12, 1'b0, c);
    chk(c == 1'b0, "R9", "no clear on echo", c, 0);
    expect_bytes(1, '{8'h12, 0, 0, 0}, "R7");
    cmd(8'hF5, 1, '{8'hF5, 0, 0, 0}, "R7");
    chk(cfg_enable == 1'b1, "R7", "echoed F5 has no effect", cfg_enable, 1);
    cmd(8'hFE, 1, '{8'hFE, 0, 0, 0}, "R7");
    cmd(8'hEC, 1, '{8'hFA, 0, 0, 0}, "R7");
    chk(cfg_wrap == 1'b0 && stream_on == 1'b1, "R7", "leave wrap to stream", stream_on, 1);
    cmd(8'hF0, 1, '{8'hFA, 0, 0, 0}, "R3");
    cmd(8'hEE, 1, '{8'hFA, 0, 0, 0}, "R7");
    send_byte(8'hEC, 1'b0, c);
    chk(c == 1'b1, "R9", "ctr_clr after EC in wrap", c, 1);
    expect_bytes(1, '{8'hFA, 0, 0, 0}, "R7");
    chk(cfg_remote == 1'b1 && cfg_wrap == 1'b0, "R7", "return to remote", cfg_remote, 1);
    cmd(8'hEE, 1, '{8'hFA, 0, 0, 0}, "R7");
    cmd(8'hFF, 3, '{8'hFA, 8'hAA, 8'h00, 0}, "R2");
    chk(cfg_wrap == 1'b0 && cfg_remote == 1'b0, "R2", "FF leaves wrap", cfg_wrap, 0);
  endtask

  task automatic t_reports;
    rpt_data = 24'h03F109;
    cmd(8'hEB, 4, '{8'hFA, 8'h09, 8'hF1, 8'h03}, "R8");
    cmd(8'hF0, 1, '{8'hFA, 0, 0, 0}, "R3");
    cmd(8'hF4, 1, '{8'hFA, 0, 0, 0}, "R3");
    cmd(8'hE7, 1, '{8'hFA, 0, 0, 0}, "R3");
    cmd(8'hE8, 1, '{8'hFA, 0, 0, 0}, "R4");
    cmd(8'h01, 1, '{8'hFA, 0, 0, 0}, "R4");
    cmd(8'hF3, 1, '{8'hFA, 0, 0, 0}, "R4");
    cmd(8'hC8, 1, '{8'hFA, 0, 0, 0}, "R4");
    btn = 3'b011;
    cmd(8'hE9, 4, '{8'hFA, 8'h75, 8'h01, 8'hC8}, "R8");
    btn = 3'b000;
    cmd(8'hFF, 3, '{8'hFA, 8'hAA, 8'h00, 0}, "R2");
  endtask

  task automatic t_queue;
    logic c;
    send_byte(8'hF2, 1'b0, c);
    for (int i = 0; i < 3; i++) begin
      chk(tx_valid == 1'b1 && tx_data == 8'hFA, "R10", "hold while stalled", tx_data, 8'hFA);
      @(negedge clk);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk(tx_valid == 1'b1 && tx_data == 8'h00, "R10", "advance on ready", tx_data, 8'h00);
    rpt_data = 24'h7E8001;
    send_byte(8'hEB, 1'b0, c);
    expect_bytes(4, '{8'hFA, 8'h01, 8'h80, 8'h7E}, "R10");
    cmd(8'hF2, 1 + 1, '{8'hFA, 8'h00, 0, 0}, "R10");
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_modes();
    t_params();
    t_resend();
    t_wrap();
    t_reports();
    t_queue();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not end, got %0d expected %0d", 0, 1);
      finish_run();
    end
  end
endmodule